// File: doc/BRIEF.md
# Configuration Access Routing Decoder

This block takes one host configuration request at a time and works out where it should go. A request names a bus, a device, a function and a 10-bit register index. It also carries a read/write flag, write data and byte enables. The block compares the bus number with the bridge's secondary and subordinate bus settings and with a mask of enabled on-chip devices. It then delivers the request to exactly one destination:

- the internal register port;
- the downstream link, as a Type 0 or Type 1 configuration request;
- the south-side link, as a Type 0 or Type 1 configuration request;
- the master-abort responder.

For both links the block builds the four header bytes that carry the routing fields. Anything that neither the on-chip devices nor the bridge window claims falls through to the south-side link by default.

The routing decision is registered. A request accepted on one clock edge appears on its output at the next edge. Each destination has its own valid/ready pair, so a stalled destination holds the request and stops further input. Link serialisation, completion tracking and the register file behind the internal port belong to neighbouring blocks.

Top module: `cfg_route_top`

## Requirements
- R1: With a valid window, a request whose bus equals `sec_bus` and whose device is 0 goes to the downstream link as Type 0 (`fwd_type1`=0).
- R2: A request whose bus equals `sec_bus` inside a valid window but whose device is non-zero is not forwarded. A read raises `ma_valid` with `ma_rdata` all ones.
- R3: A bus strictly greater than `sec_bus` and not greater than `sub_bus` goes to the downstream link as Type 1 (`fwd_type1`=1).
- R4: Bus 0 outside the window, with `int_dev_en[dev]`=1, goes to the internal port. `int_dev`, `int_fn`, `int_reg` and the forwarded write fields equal the request.
- R5: Bus 0 outside the window, with `int_dev_en[dev]`=0, goes to the south-side link as Type 0.
- R6: A non-zero bus outside the window goes to the south-side link as Type 1.
- R7: When `sub_bus` < `sec_bus` the window is empty: nothing is sent downstream, and the bus-equal-to-secondary case is routed as in R5 or R6.
- R8: `fwd_hdr` is byte 8 in [31:24], byte 9 in [23:16], byte 10 in [15:8] and byte 11 in [7:0].
  - Byte 8 is the bus number.
  - Byte 9 is device in bits [7:3] and function in bits [2:0].
  - Byte 10 is 4'b0 followed by register index bits [9:6].
  - Byte 11 is register index bits [5:0] followed by 2'b00.
- R9: `wr_posted` is high in the cycle a write request is accepted. A forwarded write appears with `fwd_write`=1 and the original data and byte enables.
- R10: An aborted write raises no output valid, but is still acknowledged on `wr_posted`.
- R11: A read request appears on its destination one clock after acceptance, and at most one destination valid is high. While the destination is not ready, the output holds stable and `req_ready` is low.
- R12: After reset every destination valid is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_reg | input | 10 | Register dword index |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables |
| sec_bus | input | 8 | Bridge secondary bus number |
| sub_bus | input | 8 | Bridge subordinate bus number |
| int_dev_en | input | 32 | Enabled on-chip devices on bus 0, one bit per device |
| wr_posted | output | 1 | Immediate write acknowledge to host |
| int_valid | output | 1 | Request for internal register port |
| int_ready | input | 1 | Internal port accepts |
| int_dev | output | 5 | Device number for internal port |
| int_fn | output | 3 | Function number for internal port |
| int_reg | output | 10 | Register index for internal port |
| dn_valid | output | 1 | Request for downstream link |
| dn_ready | input | 1 | Downstream link accepts |
| sb_valid | output | 1 | Request for south-side link |
| sb_ready | input | 1 | South-side link accepts |
| fwd_type1 | output | 1 | Link request is Type 1 |
| fwd_hdr | output | 32 | Header bytes 8..11 |
| fwd_write | output | 1 | Forwarded request is a write |
| fwd_wdata | output | DATA_W | Forwarded write data |
| fwd_be | output | DATA_W/8 | Forwarded byte enables |
| ma_valid | output | 1 | Master-abort completion for a read |
| ma_ready | input | 1 | Host takes the abort completion |
| ma_rdata | output | DATA_W | Abort read data (all ones) |

## Verification
A fixed window of secondary 4 and subordinate 9 is used with bus numbers 0, 3, 4, 5, 9 and 10. These values separate the exact-secondary match from the inside-window case and from both sides of the window edges. Device numbers 0 and 3 on the secondary bus separate a downstream Type 0 from an abort. Enabled and disabled devices on bus 0 separate an internal claim from the subtractive south-side default. The window is then inverted to show that nothing is claimed downstream. A stalled downstream destination shows that the output holds and that input is blocked.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;
    localparam int BUS_W  = 8;
    localparam int DEV_W  = 5;
    localparam int FN_W   = 3;
    localparam int REG_W  = 10;
    localparam int EXT_W  = 4;
    localparam int RNUM_W = REG_W - EXT_W;
    localparam int HDR_W  = 32;
    localparam int N_DEV  = 1 << DEV_W;

    typedef enum logic [2:0] {
        RT_INT   = 3'd0,
        RT_DN0   = 3'd1,
        RT_DN1   = 3'd2,
        RT_SB0   = 3'd3,
        RT_SB1   = 3'd4,
        RT_ABORT = 3'd5
    } route_e;
endpackage

// File: rtl/cfg_route_decide.sv
module cfg_route_decide
    import cfg_route_pkg::*;
(
    input  logic [BUS_W-1:0] bus,
    input  logic [DEV_W-1:0] dev,
    input  logic [BUS_W-1:0] sec_bus,
    input  logic [BUS_W-1:0] sub_bus,
    input  logic [N_DEV-1:0] dev_en,
    output route_e           route
);
    logic win_ok;
    logic in_win;
    logic at_sec;

    always_comb begin
        win_ok = (sub_bus >= sec_bus);
        in_win = win_ok && (bus >= sec_bus) && (bus <= sub_bus);
        at_sec = (bus == sec_bus);
        if (in_win) begin
            if (at_sec) begin
                route = (dev == '0) ? RT_DN0 : RT_ABORT;
            end else begin
                route = RT_DN1;
            end
        end else if (bus == '0) begin
            route = dev_en[dev] ? RT_INT : RT_SB0;
        end else begin
            route = RT_SB1;
        end
    end
endmodule

// File: rtl/cfg_route_hdr.sv
module cfg_route_hdr
    import cfg_route_pkg::*;
(
    input  logic [BUS_W-1:0] bus,
    input  logic [DEV_W-1:0] dev,
    input  logic [FN_W-1:0]  fn,
    input  logic [REG_W-1:0] regidx,
    output logic [HDR_W-1:0] hdr
);
    logic [7:0] b8, b9, b10, b11;

    always_comb begin
        b8  = bus;
        b9  = {dev, fn};
        b10 = {{(8-EXT_W){1'b0}}, regidx[REG_W-1 -: EXT_W]};
        b11 = {regidx[RNUM_W-1:0], 2'b00};
        hdr = {b8, b9, b10, b11};
    end
endmodule

// File: rtl/cfg_route_top.sv
module cfg_route_top
    import cfg_route_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_bus,
    input  logic [4:0]        req_dev,
    input  logic [2:0]        req_fn,
    input  logic [9:0]        req_reg,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    input  logic [7:0]        sec_bus,
    input  logic [7:0]        sub_bus,
    input  logic [31:0]       int_dev_en,
    output logic              wr_posted,
    output logic              int_valid,
    input  logic              int_ready,
    output logic [4:0]        int_dev,
    output logic [2:0]        int_fn,
    output logic [9:0]        int_reg,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic              sb_valid,
    input  logic              sb_ready,
    output logic              fwd_type1,
    output logic [31:0]       fwd_hdr,
    output logic              fwd_write,
    output logic [DATA_W-1:0] fwd_wdata,
    output logic [BE_W-1:0]   fwd_be,
    output logic              ma_valid,
    input  logic              ma_ready,
    output logic [DATA_W-1:0] ma_rdata
);
    typedef struct packed {
        logic              valid;
        route_e            route;
        logic              write;
        logic [DEV_W-1:0]  dev;
        logic [FN_W-1:0]   fn;
        logic [REG_W-1:0]  regidx;
        logic [DATA_W-1:0] wdata;
        logic [BE_W-1:0]   be;
        logic [HDR_W-1:0]  hdr;
    } stage_t;

    stage_t           st_d, st_q;
    route_e           route_w;
    logic [HDR_W-1:0] hdr_w;
    logic             sel_ready;
    logic             out_fire;
    logic             req_fire;

    cfg_route_decide u_decide (
        .bus     (req_bus),
        .dev     (req_dev),
        .sec_bus (sec_bus),
        .sub_bus (sub_bus),
        .dev_en  (int_dev_en),
        .route   (route_w)
    );

    cfg_route_hdr u_hdr (
        .bus    (req_bus),
        .dev    (req_dev),
        .fn     (req_fn),
        .regidx (req_reg),
        .hdr    (hdr_w)
    );

    always_comb begin
        unique case (st_q.route)
            RT_INT:         sel_ready = int_ready;
            RT_DN0, RT_DN1: sel_ready = dn_ready;
            RT_SB0, RT_SB1: sel_ready = sb_ready;
            default:        sel_ready = ma_ready;
        endcase
        out_fire  = st_q.valid && sel_ready;
        req_ready = !st_q.valid || out_fire;
        req_fire  = req_valid && req_ready;
        wr_posted = req_fire && req_write;

        st_d = st_q;
        if (req_fire) begin
            st_d.valid  = !((route_w == RT_ABORT) && req_write);
            st_d.route  = route_w;
            st_d.write  = req_write;
            st_d.dev    = req_dev;
            st_d.fn     = req_fn;
            st_d.regidx = req_reg;
            st_d.wdata  = req_wdata;
            st_d.be     = req_be;
            st_d.hdr    = hdr_w;
        end else if (out_fire) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        int_valid = st_q.valid && (st_q.route == RT_INT);
        dn_valid  = st_q.valid && ((st_q.route == RT_DN0) || (st_q.route == RT_DN1));
        sb_valid  = st_q.valid && ((st_q.route == RT_SB0) || (st_q.route == RT_SB1));
        ma_valid  = st_q.valid && (st_q.route == RT_ABORT);
        fwd_type1 = (st_q.route == RT_DN1) || (st_q.route == RT_SB1);
        fwd_hdr   = st_q.hdr;
        fwd_write = st_q.write;
        fwd_wdata = st_q.wdata;
        fwd_be    = st_q.be;
        int_dev   = st_q.dev;
        int_fn    = st_q.fn;
        int_reg   = st_q.regidx;
        ma_rdata  = ma_valid ? {DATA_W{1'b1}} : '0;
    end
endmodule

// File: rtl/cfg_route_chk.sv
module cfg_route_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic              int_valid,
    input logic              dn_valid,
    input logic              sb_valid,
    input logic              ma_valid,
    input logic              dn_ready,
    input logic              fwd_type1,
    input logic [31:0]       fwd_hdr,
    input logic              fwd_write,
    input logic [DATA_W-1:0] ma_rdata
);
    p_one_dest_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({int_valid, dn_valid, sb_valid, ma_valid}));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(fwd_hdr)));

    p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |-> !req_ready);

    p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=>
        (int_valid || dn_valid || sb_valid || ma_valid));

    p_type0_dev0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !fwd_type1) |-> (fwd_hdr[23:19] == 5'd0));

    p_abort_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ma_valid |-> (&ma_rdata));

    p_abort_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ma_valid |-> !fwd_write);
endmodule

bind cfg_route_top cfg_route_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/cfg_route_top_tb.sv
module cfg_route_top_tb;
    localparam int DW = 32;
    localparam int BW = DW / 8;
    localparam int P_INT = 0, P_DN = 1, P_SB = 2, P_MA = 3, P_NONE = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [7:0]    req_bus = '0;
    logic [4:0]    req_dev = '0;
    logic [2:0]    req_fn = '0;
    logic [9:0]    req_reg = '0;
    logic          req_write = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic [BW-1:0] req_be = '0;
    logic [7:0]    sec_bus = 8'd4;
    logic [7:0]    sub_bus = 8'd9;
    logic [31:0]   int_dev_en = 32'h0000_0005;
    logic          wr_posted;
    logic          int_valid, int_ready = 1'b1;
    logic [4:0]    int_dev;
    logic [2:0]    int_fn;
    logic [9:0]    int_reg;
    logic          dn_valid, dn_ready = 1'b1;
    logic          sb_valid, sb_ready = 1'b1;
    logic          fwd_type1;
    logic [31:0]   fwd_hdr;
    logic          fwd_write;
    logic [DW-1:0] fwd_wdata;
    logic [BW-1:0] fwd_be;
    logic          ma_valid, ma_ready = 1'b1;
    logic [DW-1:0] ma_rdata;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cfg_route_top #(.DATA_W(DW)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_hdr(input logic [7:0] b, input logic [4:0] d,
                                            input logic [2:0] f, input logic [9:0] r);
        return {b, d, f, 4'h0, r[9:6], r[5:0], 2'b00};
    endfunction

    task automatic send(input string req, input logic [7:0] b, input logic [4:0] d,
                        input logic [2:0] f, input logic [9:0] r, input bit wr,
                        input logic [DW-1:0] wd, input logic [BW-1:0] be,
                        input int port, input bit t1);
        logic [3:0] expv;
        logic [3:0] actv;
        @(negedge clk);
        req_bus = b; req_dev = d; req_fn = f; req_reg = r;
        req_write = wr; req_wdata = wd; req_be = be; req_valid = 1'b1;
        #1;
        chk(wr_posted == wr, wr ? "R9" : req, "posted ack", 64'(wr_posted), 64'(wr));
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        expv = (port == P_NONE) ? 4'b0000 : 4'(1 << port);
        actv = {ma_valid, sb_valid, dn_valid, int_valid};
        chk(actv == expv, req, "destination", 64'(actv), 64'(expv));
        if (port == P_DN || port == P_SB) begin
            chk(fwd_type1 == t1, req, "type", 64'(fwd_type1), 64'(t1));
            chk(fwd_hdr == exp_hdr(b, d, f, r), "R8", "header",
                64'(fwd_hdr), 64'(exp_hdr(b, d, f, r)));
        end
        if (port == P_INT) begin
            chk({int_dev, int_fn, int_reg} == {d, f, r}, req, "internal fields",
                64'({int_dev, int_fn, int_reg}), 64'({d, f, r}));
        end
        if (port == P_MA) begin
            chk(ma_rdata == '1, req, "abort data", 64'(ma_rdata), 64'(32'hFFFF_FFFF));
        end
        if (wr && port != P_MA && port != P_NONE) begin
            chk(fwd_write && fwd_wdata == wd && fwd_be == be, "R9", "write fields",
                64'({fwd_write, fwd_be, fwd_wdata}), 64'({1'b1, be, wd}));
        end
        @(negedge clk);
    endtask

    task automatic t_reset;
        #1;
        chk({int_valid, dn_valid, sb_valid, ma_valid} == 4'b0, "R12", "valids",
            64'({int_valid, dn_valid, sb_valid, ma_valid}), 64'(0));
        chk(req_ready == 1'b1, "R12", "req_ready", 64'(req_ready), 64'(1));
    endtask

    task automatic t_downstream;
        send("R1", 8'd4, 5'd0, 3'd3, 10'h2A5, 1'b0, '0, '0, P_DN, 1'b0);
        send("R2", 8'd4, 5'd3, 3'd0, 10'h010, 1'b0, '0, '0, P_MA, 1'b0);
        send("R10", 8'd4, 5'd3, 3'd1, 10'h011, 1'b1, 32'hDEAD_BEEF, 4'hF, P_NONE, 1'b0);
        send("R3", 8'd9, 5'd7, 3'd5, 10'h3FF, 1'b1, 32'h1234_5678, 4'h6, P_DN, 1'b1);
        send("R3", 8'd5, 5'd1, 3'd0, 10'h040, 1'b0, '0, '0, P_DN, 1'b1);
    endtask

    task automatic t_bus0;
        send("R4", 8'd0, 5'd2, 3'd6, 10'h155, 1'b1, 32'hA5A5_0F0F, 4'h3, P_INT, 1'b0);
        send("R4", 8'd0, 5'd0, 3'd1, 10'h001, 1'b0, '0, '0, P_INT, 1'b0);
        send("R5", 8'd0, 5'd5, 3'd2, 10'h0C3, 1'b0, '0, '0, P_SB, 1'b0);
    endtask

    task automatic t_outside;
        send("R6", 8'd10, 5'd4, 3'd0, 10'h200, 1'b0, '0, '0, P_SB, 1'b1);
        send("R6", 8'd3, 5'd0, 3'd7, 10'h07F, 1'b1, 32'h0000_00FF, 4'h1, P_SB, 1'b1);
    endtask

    task automatic t_bad_window;
        sec_bus = 8'd8; sub_bus = 8'd6;
        send("R7", 8'd8, 5'd0, 3'd0, 10'h004, 1'b0, '0, '0, P_SB, 1'b1);
        send("R7", 8'd7, 5'd2, 3'd0, 10'h004, 1'b0, '0, '0, P_SB, 1'b1);
        send("R7", 8'd0, 5'd2, 3'd0, 10'h004, 1'b0, '0, '0, P_INT, 1'b0);
        sec_bus = 8'd4; sub_bus = 8'd9;
    endtask

    task automatic t_backpressure;
        logic [31:0] h0;
        dn_ready = 1'b0;
        @(negedge clk);
        req_bus = 8'd6; req_dev = 5'd1; req_fn = 3'd1; req_reg = 10'h0AA;
        req_write = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        h0 = fwd_hdr;
        chk(dn_valid == 1'b1, "R11", "stalled valid", 64'(dn_valid), 64'(1));
        @(negedge clk);
        #1;
        chk(dn_valid == 1'b1 && fwd_hdr == h0, "R11", "held output",
            64'({dn_valid, fwd_hdr}), 64'({1'b1, h0}));
        chk(req_ready == 1'b0, "R11", "input blocked", 64'(req_ready), 64'(0));
        dn_ready = 1'b1;
        @(negedge clk);
        #1;
        chk(dn_valid == 1'b0 && req_ready == 1'b1, "R11", "drained",
            64'({dn_valid, req_ready}), 64'(2'b01));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_downstream();
        t_bus0();
        t_outside();
        t_bad_window();
        t_backpressure();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule